// File: doc/BRIEF.md
# Retire-Cycle Sample Snapshot

This block sits next to the retire stage of a superscalar core. Every cycle it sees the retire bundle. The bundle carries, for each slot, a valid bit, a PC, a flag that marks a taken control transfer and that transfer's destination, and a set of cause event bits. Slot 0 is the oldest. The block also sees stall and flush status from the pipeline, a flag that says the first slot that did not retire was held back, and a single-cycle sample trigger.

When a trigger arrives and no sample is waiting, the block condenses that retire cycle into three things:
- one sample PC;
- a packed 64-bit details word;
- up to two control-transfer destination PCs.

It then raises a pending flag. While the flag is up, the captured values stay frozen and further triggers are ignored. Software reads the values and pulses a clear.

Profiling software uses the details word to spread the sampled cycle over every instruction that retired in it. It starts from the sample PC, follows the recorded transfers, and charges lost retire bandwidth to the one instruction that blocked retirement.

Top module: `retire_sample_capture`

## Requirements
- R1: Details bits [3:0] hold the retired count. This is the number of consecutive valid slots starting at slot 0. A valid slot after an invalid one is not counted.
- R2: Details bits [5:4] hold the retire state, chosen in this priority: 00 if the retired count is non-zero; otherwise 10 if flush is high; otherwise 01 if stall is high; otherwise 11.
- R3: Details bits [9:6] hold the number of retired slots whose transfer flag is set. This includes transfers beyond the second.
- R4: Details bits [13:10] and [17:14] hold the positions of the first and second transfers. A position is the slot index plus 1, so a transfer between the oldest and the next instruction reads 1. The destinations of those two transfers go to target outputs 1 and 2.
- R5: When fewer than two transfers are counted, the unused position fields and target outputs read zero. Targets of a third or later transfer are dropped.
- R6: Details bits [21:18] hold the cause pointer. It equals the retired count plus 1 when the blocked flag is high and the retired count is below the retire width; otherwise it is 0.
- R6 (continued): Details bits [31:22] hold that slot's cause bits, zero-extended, or zero when the pointer is 0. The fixed cause bits are, from bit 0 upward: instruction-cache miss, instruction-TLB miss, branch mispredict, data-cache miss, data-TLB miss.
- R7: The sample PC is the PC in slot 0. That slot holds either the oldest retired instruction or the head instruction responsible for a non-retiring state.
- R8: Details bits [63:32] read zero.
- R9: A trigger while nothing is pending captures that cycle's values. The outputs and a raised pending flag appear one cycle later.
- R10: While a sample is pending and no clear is given, triggers have no effect and every captured output holds its value.
- R11: A clear without a trigger drops pending and leaves the captured values in place. A clear together with a trigger captures the new cycle and keeps pending high.
- R12: After reset, pending is low and every captured output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_valid | input | W | Per-slot retire valid, slot 0 oldest |
| ret_pc | input | W*PCW | Per-slot PC, slot i at bits [i*PCW +: PCW] |
| ret_ct | input | W | Per-slot taken control-transfer flag |
| ret_tgt | input | W*PCW | Per-slot transfer destination PC |
| ret_cause | input | W*CW | Per-slot cause event bits |
| ret_blocked | input | 1 | First non-retired slot blocked retirement |
| stall | input | 1 | Pipeline stalled this cycle |
| flush | input | 1 | Pipeline flushing this cycle |
| sample_trig | input | 1 | Sample trigger pulse |
| sample_clr | input | 1 | Clear the pending sample |
| smp_pending | output | 1 | A captured sample is waiting |
| smp_pc | output | PCW | Captured sample PC |
| smp_details | output | 64 | Captured packed details word |
| smp_tgt1 | output | PCW | Captured first transfer destination |
| smp_tgt2 | output | PCW | Captured second transfer destination |

## Verification
A clear from software and a new trigger can arrive in the same cycle. The block must then release the old sample and latch the new one without a gap in the pending flag. The bench provokes this by holding a sample, driving a different bundle, and pulsing clear and trigger on the same edge. It passes only if every output matches the new bundle and pending stays high. The reverse case, a trigger while still pending, is judged by checking that every output keeps the earlier sample. Around both cases, an exhaustive sweep covers every retired length (including gaps in the valid bits), every transfer pattern, and every combination of blocked, stall and flush.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   localparam int DETAIL_W = 64;
   localparam int CAUSE_FW = 10;
   localparam int PACK_W   = 32;

   typedef enum logic [1:0] {
      RS_RETIRE = 2'b00,
      RS_STALL  = 2'b01,
      RS_FLUSH  = 2'b10,
      RS_EMPTY  = 2'b11
   } rstate_e;

   // packed from MSB down, so the count lands at bit 0
   typedef struct packed {
      logic [CAUSE_FW-1:0] cause;
      logic [3:0]          coff;
      logic [3:0]          off2;
      logic [3:0]          off1;
      logic [3:0]          ctn;
      rstate_e             st;
      logic [3:0]          cnt;
   } details_t;

   function automatic logic [3:0] sat4(input logic [4:0] v);
      return (v > 5'd15) ? 4'd15 : v[3:0];
   endfunction
endpackage

// File: rtl/rsc_scan.sv
module rsc_scan import rsc_pkg::*; #(
   parameter int W   = 4,
   parameter int PCW = 32
) (
   input  logic [W-1:0]     valid,
   input  logic [W-1:0]     ct,
   input  logic [W*PCW-1:0] tgt,
   output logic [3:0]       cnt,
   output logic [3:0]       ctn,
   output logic [3:0]       off1,
   output logic [3:0]       off2,
   output logic [PCW-1:0]   tgt1,
   output logic [PCW-1:0]   tgt2
);
   logic [4:0] run;
   logic [4:0] nct;

   // retired length: unbroken run of valid slots from the oldest
   always_comb begin
      logic alive;
      alive = 1'b1;
      run   = '0;
      for (int i = 0; i < W; i++) begin
         if (alive && valid[i]) run = run + 5'd1;
         else                   alive = 1'b0;
      end
   end

   // first two transfers among retired slots; later ones only counted
   always_comb begin
      nct  = '0;
      off1 = '0;
      off2 = '0;
      tgt1 = '0;
      tgt2 = '0;
      for (int i = 0; i < W; i++) begin
         if ((5'(i) < run) && ct[i]) begin
            nct = nct + 5'd1;
            if (nct == 5'd1) begin
               off1 = sat4(5'(i + 1));
               tgt1 = tgt[i*PCW +: PCW];
            end else if (nct == 5'd2) begin
               off2 = sat4(5'(i + 1));
               tgt2 = tgt[i*PCW +: PCW];
            end
         end
      end
   end

   assign cnt = sat4(run);
   assign ctn = sat4(nct);
endmodule

// File: rtl/rsc_blame.sv
module rsc_blame import rsc_pkg::*; #(
   parameter int W  = 4,
   parameter int CW = 10
) (
   input  logic [3:0]          cnt,
   input  logic                blocked,
   input  logic                stall,
   input  logic                flush,
   input  logic [W*CW-1:0]     cause_in,
   output rstate_e             st,
   output logic [3:0]          coff,
   output logic [CAUSE_FW-1:0] cause
);
   logic [CW-1:0] sel;
   logic          has_blk;

   always_comb begin
      if (cnt != 4'd0) st = RS_RETIRE;
      else if (flush)  st = RS_FLUSH;
      else if (stall)  st = RS_STALL;
      else             st = RS_EMPTY;
   end

   assign has_blk = blocked && (5'(cnt) < 5'(W));

   // cause bits of the first slot that did not retire
   always_comb begin
      sel = '0;
      for (int i = 0; i < W; i++)
         if (cnt == 4'(i)) sel = cause_in[i*CW +: CW];
   end

   generate
      if (CW == CAUSE_FW) begin : g_full
         assign cause = has_blk ? sel : '0;
      end else begin : g_ext
         assign cause = has_blk ? {{(CAUSE_FW-CW){1'b0}}, sel} : '0;
      end
   endgenerate

   assign coff = has_blk ? sat4(5'(cnt) + 5'd1) : 4'd0;
endmodule

// File: rtl/retire_sample_capture.sv
module retire_sample_capture import rsc_pkg::*; #(
   parameter int W   = 4,
   parameter int PCW = 32,
   parameter int CW  = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [W-1:0]        ret_valid,
   input  logic [W*PCW-1:0]    ret_pc,
   input  logic [W-1:0]        ret_ct,
   input  logic [W*PCW-1:0]    ret_tgt,
   input  logic [W*CW-1:0]     ret_cause,
   input  logic                ret_blocked,
   input  logic                stall,
   input  logic                flush,
   input  logic                sample_trig,
   input  logic                sample_clr,
   output logic                smp_pending,
   output logic [PCW-1:0]      smp_pc,
   output logic [DETAIL_W-1:0] smp_details,
   output logic [PCW-1:0]      smp_tgt1,
   output logic [PCW-1:0]      smp_tgt2
);
   localparam int RSV_W = DETAIL_W - PACK_W;

   generate
      if (W < 1 || W > 8) begin : g_bad_w
         $error("retire width must lie in 1..8");
      end
      if (CW < 5 || CW > CAUSE_FW) begin : g_bad_cw
         $error("cause width must lie in 5..10");
      end
      if (PCW < 2) begin : g_bad_pcw
         $error("PC width too small");
      end
   endgenerate

   logic [3:0]     cnt, ctn, off1, off2, coff;
   logic [PCW-1:0] tgt1, tgt2;
   rstate_e        st;
   logic [CAUSE_FW-1:0] cause;
   details_t       det;
   logic           take;

   rsc_scan #(.W(W), .PCW(PCW)) u_scan (
      .valid (ret_valid),
      .ct    (ret_ct),
      .tgt   (ret_tgt),
      .cnt   (cnt),
      .ctn   (ctn),
      .off1  (off1),
      .off2  (off2),
      .tgt1  (tgt1),
      .tgt2  (tgt2)
   );

   rsc_blame #(.W(W), .CW(CW)) u_blame (
      .cnt      (cnt),
      .blocked  (ret_blocked),
      .stall    (stall),
      .flush    (flush),
      .cause_in (ret_cause),
      .st       (st),
      .coff     (coff),
      .cause    (cause)
   );

   always_comb begin
      det.cnt   = cnt;
      det.st    = st;
      det.ctn   = ctn;
      det.off1  = off1;
      det.off2  = off2;
      det.coff  = coff;
      det.cause = cause;
   end

   // a clear in the same cycle frees the slot for the new trigger
   assign take = sample_trig && (!smp_pending || sample_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_pending <= 1'b0;
         smp_pc      <= '0;
         smp_details <= '0;
         smp_tgt1    <= '0;
         smp_tgt2    <= '0;
      end else begin
         if (take) begin
            smp_pending <= 1'b1;
            smp_pc      <= ret_pc[PCW-1:0];
            smp_details <= {{RSV_W{1'b0}}, det};
            smp_tgt1    <= tgt1;
            smp_tgt2    <= tgt2;
         end else if (sample_clr) begin
            smp_pending <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/retire_sample_capture_chk.sv
module retire_sample_capture_chk #(
   parameter int W   = 4,
   parameter int PCW = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           sample_trig,
   input logic           sample_clr,
   input logic           smp_pending,
   input logic [PCW-1:0] smp_pc,
   input logic [63:0]    smp_details,
   input logic [PCW-1:0] smp_tgt1,
   input logic [PCW-1:0] smp_tgt2
);
   assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_trig && !smp_pending) |=> smp_pending);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_pending && !sample_clr) |=> ($stable(smp_pc) && $stable(smp_details)
         && $stable(smp_tgt1) && $stable(smp_tgt2) && smp_pending));

   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_clr && !sample_trig) |=> (!smp_pending && $stable(smp_details)));

   assert_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_details[3:0] != 4'd0) |-> (smp_details[5:4] == 2'b00));

   assert_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_details[9:6] < 4'd2) |-> (smp_tgt2 == '0 && smp_details[17:14] == 4'd0));

   assert_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, smp_details[21:18]} <= {1'b0, smp_details[3:0]} + 5'd1));

   assert_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, smp_details[3:0]} <= 5'(W)));
endmodule

bind retire_sample_capture retire_sample_capture_chk #(.W(W), .PCW(PCW)) u_chk (.*);

// File: tb/retire_sample_capture_test.sv
`timescale 1ns/1ps
module retire_sample_capture_test;
   localparam int W   = 4;
   localparam int PCW = 16;
   localparam int CW  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0]     ret_valid = '0;
   logic [W*PCW-1:0] ret_pc = '0;
   logic [W-1:0]     ret_ct = '0;
   logic [W*PCW-1:0] ret_tgt = '0;
   logic [W*CW-1:0]  ret_cause = '0;
   logic ret_blocked = 1'b0, stall = 1'b0, flush = 1'b0;
   logic sample_trig = 1'b0, sample_clr = 1'b0;
   logic           smp_pending;
   logic [PCW-1:0] smp_pc, smp_tgt1, smp_tgt2;
   logic [63:0]    smp_details;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   retire_sample_capture #(.W(W), .PCW(PCW), .CW(CW)) uut (.*);

   logic [63:0]    e_det;
   logic [PCW-1:0] e_pc, e_t1, e_t2;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input int k, input logic [W-1:0] v, input logic [W-1:0] c,
                        input logic blk, input logic st, input logic fl);
      ret_valid = v; ret_ct = c; ret_blocked = blk; stall = st; flush = fl;
      for (int i = 0; i < W; i++) begin
         ret_pc[i*PCW +: PCW]   = PCW'(16'h1000 + k*8 + i*2);
         ret_tgt[i*PCW +: PCW]  = PCW'(16'hA000 + k + i*16'h100);
         ret_cause[i*CW +: CW]  = CW'(k*7 + i*3 + 1);
      end
   endtask

   // expected fields worked out from the requirement text
   task automatic expect_of(input int k);
      int run, n, o1, o2, co, s;
      logic [9:0] cz;
      run = 0;
      while (run < W && ret_valid[run]) run++;
      n = 0; o1 = 0; o2 = 0; e_t1 = '0; e_t2 = '0;
      for (int i = 0; i < run; i++)
         if (ret_ct[i]) begin
            n++;
            if (n == 1) begin o1 = i + 1; e_t1 = PCW'(16'hA000 + k + i*16'h100); end
            if (n == 2) begin o2 = i + 1; e_t2 = PCW'(16'hA000 + k + i*16'h100); end
         end
      s  = (run > 0) ? 0 : (flush ? 2 : (stall ? 1 : 3));
      co = (ret_blocked && run < W) ? run + 1 : 0;
      cz = (co != 0) ? 10'(k*7 + run*3 + 1) : 10'd0;
      e_pc  = PCW'(16'h1000 + k*8);
      e_det = {32'd0, cz, 4'(co), 4'(o2), 4'(o1), 4'(n), 2'(s), 4'(run)};
   endtask

   task automatic check_all(input string tag);
      check({"R1 count ", tag},   {60'd0, smp_details[3:0]},   {60'd0, e_det[3:0]});
      check({"R2 state ", tag},   {62'd0, smp_details[5:4]},   {62'd0, e_det[5:4]});
      check({"R3 ctcount ", tag}, {60'd0, smp_details[9:6]},   {60'd0, e_det[9:6]});
      check({"R4 offsets ", tag}, {56'd0, smp_details[17:10]}, {56'd0, e_det[17:10]});
      check({"R4_R5 targets ", tag}, {32'd0, smp_tgt1, smp_tgt2}, {32'd0, e_t1, e_t2});
      check({"R6 cause ", tag},   {50'd0, smp_details[31:18]}, {50'd0, e_det[31:18]});
      check({"R7 pc ", tag},      {48'd0, smp_pc},             {48'd0, e_pc});
      check({"R8 reserved ", tag}, {32'd0, smp_details[63:32]}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R12 pending after reset", {63'd0, smp_pending}, 64'd0);
      check("R12 outputs after reset", {smp_details ^ {smp_pc, smp_tgt1, smp_tgt2, 16'd0}}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 idle after release", {63'd0, smp_pending}, 64'd0);

      // exhaustive sweep: run length (with gaps), transfer pattern, blocked, stall/flush
      begin
         int k;
         k = 0;
         for (int r = 0; r <= W; r++)
            for (int c = 0; c < (1 << W); c++)
               for (int b = 0; b < 2; b++)
                  for (int sf = 0; sf < 4; sf++) begin
                     logic [W-1:0] v;
                     v = W'((1 << r) - 1);
                     if (r + 1 < W && (c & 1)) v[r+1] = 1'b1;  // gap after the run
                     drive(k, v, W'(c), b[0], sf[0], sf[1]);
                     expect_of(k);
                     sample_trig = 1'b1;
                     @(negedge clk);
                     sample_trig = 1'b0;
                     check("R9 pending after trigger", {63'd0, smp_pending}, 64'd1);
                     check_all("sweep");
                     sample_clr = 1'b1;
                     @(negedge clk);
                     sample_clr = 1'b0;
                     check("R11 clear drops pending", {63'd0, smp_pending}, 64'd0);
                     check("R11 clear keeps values", smp_details, e_det);
                     k++;
                  end
      end

      // a trigger while pending is ignored
      drive(3, 4'b0111, 4'b0101, 1'b1, 1'b0, 1'b0);
      expect_of(3);
      sample_trig = 1'b1; @(negedge clk); sample_trig = 1'b0;
      check_all("first capture");
      drive(9, 4'b0001, 4'b0001, 1'b0, 1'b1, 1'b0);
      sample_trig = 1'b1; @(negedge clk); sample_trig = 1'b0;
      @(negedge clk);
      check("R10 pending stays", {63'd0, smp_pending}, 64'd1);
      check_all("R10 ignored trigger");

      // clear and trigger in the same cycle capture the new bundle
      drive(11, 4'b1111, 4'b1011, 1'b0, 1'b0, 1'b0);
      expect_of(11);
      sample_clr = 1'b1; sample_trig = 1'b1;
      @(negedge clk);
      sample_clr = 1'b0; sample_trig = 1'b0;
      check("R11 pending kept on clear+trigger", {63'd0, smp_pending}, 64'd1);
      check_all("R11 clear+trigger");

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule